// File: doc/BRIEF.md
# GPIO Line Interrupt Controller

This block turns the inputs of three 8-bit ports (A, B and F) into interrupt requests. Each line has its own trigger settings. A mode bit picks level or edge sensing, and a polarity bit picks high/rising or low/falling. An enable bit gates the line. An optional filter rejects short glitches. Edge events are held in a sticky per-line flag until software clears that flag through a write-one-to-clear register. Level events are never stored: they follow the input while the condition holds.

Software reaches every setting over a simple synchronous register bus: an 8-bit address, 8-bit write data, a write strobe, and read data that follows the address combinationally. Lines from ports A and B share one merged interrupt output. Each port F line has its own output. Every port also has a pin-data register and a pin-direction register. These are plain storage for software and do not affect interrupt logic.

Top module: `gpioirq_ctrl`

## Requirements
- R1: In level mode (mode bit 0), an enabled line is pending while its qualified input equals its polarity bit (1 = high, 0 = low). It stops being pending as soon as the input leaves that level; nothing is stored.
- R2: In edge mode (mode bit 1), an enabled line latches a pending flag on a rising edge when its polarity bit is 1, or on a falling edge when it is 0. The flag stays set after the input returns.
- R3: Writing the per-port clear register clears the latched flag of every line whose data bit is 1. Zero bits leave their flags unchanged. A new edge arriving in the same cycle as the clear keeps its line pending.
- R4: A line whose enable bit is 0 is never pending and latches no edges. Changing its mode or polarity while disabled, then enabling it, creates no pending flag.
- R5: Each pin passes two synchronizing flops. With the filter off, a level-mode change on a pin shows at the outputs on the second rising clock edge after the pin changes.
- R6: With a line's filter bit set, a new input value reaches the detector only after the synchronized value has differed from the filtered value on 4 consecutive sample ticks. A sample tick occurs every TICK_DIV clocks. Shorter pulses are ignored.
- R7: `irq_ab` is the OR of all pending lines of ports A and B. `irq_f[i]` is the pending state of port F line i.
- R8: Reading 0xA0 returns port A's pending vector, and reading 0xBC returns port B's (bit i = line i enabled and pending).
- R9: The configuration registers are mode/polarity/clear/enable/filter. They sit at 0x90/0x94/0x98/0x9C/0xA8 for port A, 0xAC/0xB0/0xB4/0xB8/0xC4 for port B, and 0x4C/0x50/0x54/0x58/0x64 for port F. All except clear read back the last written value. Clear reads 0.
- R10: The pin-data/direction registers at 0x00/0x10 (A), 0x04/0x14 (B) and 0x30/0x34 (F) read back the last written value. Any unmapped address reads 0.
- R11: After synchronous reset, every register reads 0 and all interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_a | input | 8 | Port A line inputs |
| pin_b | input | 8 | Port B line inputs |
| pin_f | input | 8 | Port F line inputs |
| irq_ab | output | 1 | Merged request for ports A and B |
| irq_f | output | 8 | Per-line requests for port F |

## Verification
Several properties are checked on every cycle:
- A latched flag cannot appear on a disabled line or on a line in level mode.
- Bits written as 1 to the clear register are gone the following cycle unless a fresh edge arrived with the clear.
- The filtered value moves only on a sample tick, and the tick never lasts two cycles.

Other behaviour needs directed and random stimulus compared with the bench's reference model:
- the exact synchronizer latency;
- glitch rejection shorter than four ticks;
- the clear/edge collision;
- the merging of A and B;
- the whole address map.

// File: rtl/gpioirq_pkg.sv
package gpioirq_pkg;

    localparam int LINES = 8;
    localparam int NPORT = 3;
    localparam int AW    = 8;
    localparam int DW    = LINES;

    localparam int IDX_A = 0;
    localparam int IDX_B = 1;
    localparam int IDX_F = 2;

    typedef logic [LINES-1:0] line_vec_t;

    typedef enum logic [2:0] {
        RK_MODE, RK_POL, RK_CLR, RK_EN, RK_FILT, RK_STAT, RK_DATA, RK_DIR
    } reg_kind_e;

    typedef struct packed {
        line_vec_t mode;
        line_vec_t pol;
        line_vec_t en;
        line_vec_t filt;
        line_vec_t data;
        line_vec_t dir;
    } port_cfg_t;

    typedef struct packed {
        logic wr_mode;
        logic wr_pol;
        logic wr_clr;
        logic wr_en;
        logic wr_filt;
        logic wr_data;
        logic wr_dir;
    } port_wr_t;

    function automatic logic has_status(input int p);
        return p != IDX_F;
    endfunction

    function automatic logic [AW-1:0] reg_addr(input int p, input reg_kind_e k);
        logic [AW-1:0] a;
        a = 8'hFF;
        case (p)
            IDX_A: case (k)
                RK_MODE: a = 8'h90;  RK_POL:  a = 8'h94;
                RK_CLR:  a = 8'h98;  RK_EN:   a = 8'h9C;
                RK_STAT: a = 8'hA0;  RK_FILT: a = 8'hA8;
                RK_DATA: a = 8'h00;  RK_DIR:  a = 8'h10;
                default: a = 8'hFF;
            endcase
            IDX_B: case (k)
                RK_MODE: a = 8'hAC;  RK_POL:  a = 8'hB0;
                RK_CLR:  a = 8'hB4;  RK_EN:   a = 8'hB8;
                RK_STAT: a = 8'hBC;  RK_FILT: a = 8'hC4;
                RK_DATA: a = 8'h04;  RK_DIR:  a = 8'h14;
                default: a = 8'hFF;
            endcase
            IDX_F: case (k)
                RK_MODE: a = 8'h4C;  RK_POL:  a = 8'h50;
                RK_CLR:  a = 8'h54;  RK_EN:   a = 8'h58;
                RK_FILT: a = 8'h64;  RK_DATA: a = 8'h30;
                RK_DIR:  a = 8'h34;
                default: a = 8'hFF;
            endcase
            default: a = 8'hFF;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/gpioirq_tick.sv
module gpioirq_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    if (DIV <= 1) begin : g_every
        assign tick_o = 1'b1;
    end else begin : g_div
        localparam int CW = $clog2(DIV);
        localparam logic [CW-1:0] LAST = CW'(DIV - 1);
        logic [CW-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst)                cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + CW'(1);
        end

        assign tick_o = (cnt_q == LAST);

        // R6: sample tick is a single-cycle pulse
        a_r6_tick_single: assert property (@(posedge clk) disable iff (rst)
            tick_o |=> !tick_o);
    end
endmodule

// File: rtl/gpioirq_filter.sv
module gpioirq_filter #(
    parameter int W      = 8,
    parameter int STABLE = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] filt_o
);
    localparam int CW = (STABLE > 1) ? $clog2(STABLE) : 1;
    localparam logic [CW-1:0] RUN_LAST = CW'(STABLE - 1);

    logic [W-1:0] meta_q, sync_q;

    // two-flop synchronizer (R5)
    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;

    for (genvar i = 0; i < W; i++) begin : g_line
        logic [CW-1:0] run_q;
        logic          held_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                run_q  <= '0;
                held_q <= 1'b0;
            end else if (tick) begin
                if (sync_q[i] == held_q) begin
                    run_q <= '0;
                end else if (run_q == RUN_LAST) begin
                    held_q <= sync_q[i];
                    run_q  <= '0;
                end else begin
                    run_q <= run_q + CW'(1);
                end
            end
        end

        assign filt_o[i] = held_q;
    end

    // R6: filtered value only moves on a sample tick
    a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(filt_o));
endmodule

// File: rtl/gpioirq_port.sv
module gpioirq_port
    import gpioirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  port_wr_t  wr,
    input  line_vec_t wdata,
    input  line_vec_t sync_i,
    input  line_vec_t filt_i,
    output port_cfg_t cfg_o,
    output line_vec_t stat_o
);
    port_cfg_t cfg_q;
    line_vec_t prev_q, latch_q;
    line_vec_t qual_w, rise_w, fall_w, set_w, clr_w, lvl_w;

    always_comb begin
        qual_w = (cfg_q.filt & filt_i) | (~cfg_q.filt & sync_i);
        rise_w = qual_w & ~prev_q;
        fall_w = ~qual_w & prev_q;
        set_w  = cfg_q.en & cfg_q.mode &
                 ((cfg_q.pol & rise_w) | (~cfg_q.pol & fall_w));
        clr_w  = wr.wr_clr ? wdata : '0;
        lvl_w  = ~(qual_w ^ cfg_q.pol);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            prev_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q  <= qual_w;
            latch_q <= (latch_q & ~clr_w) | set_w;
            if (wr.wr_mode) cfg_q.mode <= wdata;
            if (wr.wr_pol)  cfg_q.pol  <= wdata;
            if (wr.wr_en)   cfg_q.en   <= wdata;
            if (wr.wr_filt) cfg_q.filt <= wdata;
            if (wr.wr_data) cfg_q.data <= wdata;
            if (wr.wr_dir)  cfg_q.dir  <= wdata;
        end
    end

    assign cfg_o  = cfg_q;
    assign stat_o = cfg_q.en & ((cfg_q.mode & latch_q) | (~cfg_q.mode & lvl_w));

    // R3: bits written as one leave no flag unless an edge arrived with them
    a_r3_clear_takes: assert property (@(posedge clk) disable iff (rst)
        wr.wr_clr |=> ((latch_q & $past(wdata & ~set_w)) == '0));

    // R4: no new flag on a line that was disabled
    a_r4_no_latch_disabled: assert property (@(posedge clk) disable iff (rst)
        ((latch_q & ~$past(latch_q) & ~$past(cfg_q.en)) == '0));

    // R2: new flags only on lines in edge mode
    a_r2_latch_needs_edge_mode: assert property (@(posedge clk) disable iff (rst)
        ((latch_q & ~$past(latch_q) & ~$past(cfg_q.mode)) == '0));
endmodule

// File: rtl/gpioirq_ctrl.sv
module gpioirq_ctrl
    import gpioirq_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int FILT_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             bus_we,
    output logic [DW-1:0]    bus_rdata,
    input  logic [LINES-1:0] pin_a,
    input  logic [LINES-1:0] pin_b,
    input  logic [LINES-1:0] pin_f,
    output logic             irq_ab,
    output logic [LINES-1:0] irq_f
);
    logic      tick;
    line_vec_t pins   [NPORT];
    line_vec_t sync_w [NPORT];
    line_vec_t filt_w [NPORT];
    line_vec_t stat   [NPORT];
    port_cfg_t cfg    [NPORT];

    assign pins[IDX_A] = pin_a;
    assign pins[IDX_B] = pin_b;
    assign pins[IDX_F] = pin_f;

    gpioirq_tick #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        port_wr_t wr_l;

        always_comb begin
            wr_l.wr_mode = bus_we && (bus_addr == reg_addr(p, RK_MODE));
            wr_l.wr_pol  = bus_we && (bus_addr == reg_addr(p, RK_POL));
            wr_l.wr_clr  = bus_we && (bus_addr == reg_addr(p, RK_CLR));
            wr_l.wr_en   = bus_we && (bus_addr == reg_addr(p, RK_EN));
            wr_l.wr_filt = bus_we && (bus_addr == reg_addr(p, RK_FILT));
            wr_l.wr_data = bus_we && (bus_addr == reg_addr(p, RK_DATA));
            wr_l.wr_dir  = bus_we && (bus_addr == reg_addr(p, RK_DIR));
        end

        gpioirq_filter #(.W(LINES), .STABLE(FILT_LEN)) u_filter (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .pin_i  (pins[p]),
            .sync_o (sync_w[p]),
            .filt_o (filt_w[p])
        );

        gpioirq_port u_port (
            .clk    (clk),
            .rst    (rst),
            .wr     (wr_l),
            .wdata  (bus_wdata),
            .sync_i (sync_w[p]),
            .filt_i (filt_w[p]),
            .cfg_o  (cfg[p]),
            .stat_o (stat[p])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (bus_addr == reg_addr(p, RK_MODE)) bus_rdata = cfg[p].mode;
            if (bus_addr == reg_addr(p, RK_POL))  bus_rdata = cfg[p].pol;
            if (bus_addr == reg_addr(p, RK_EN))   bus_rdata = cfg[p].en;
            if (bus_addr == reg_addr(p, RK_FILT)) bus_rdata = cfg[p].filt;
            if (bus_addr == reg_addr(p, RK_DATA)) bus_rdata = cfg[p].data;
            if (bus_addr == reg_addr(p, RK_DIR))  bus_rdata = cfg[p].dir;
            if (has_status(p) && bus_addr == reg_addr(p, RK_STAT))
                bus_rdata = stat[p];
        end
    end

    assign irq_ab = (|stat[IDX_A]) | (|stat[IDX_B]);
    assign irq_f  = stat[IDX_F];
endmodule

// File: tb/gpioirq_ctrl_bench.sv
module gpioirq_ctrl_bench;
    localparam int TDIV = 4;
    localparam int FLEN = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_a = '0, pin_b = '0, pin_f = '0;
    logic       irq_ab;
    logic [7:0] irq_f;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    gpioirq_ctrl #(.TICK_DIV(TDIV), .FILT_LEN(FLEN)) u_gpioirq_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_a(pin_a), .pin_b(pin_b),
        .pin_f(pin_f), .irq_ab(irq_ab), .irq_f(irq_f)
    );

    // kinds: 0 mode, 1 pol, 2 clr, 3 en, 4 filt, 5 stat, 6 data, 7 dir
    function automatic int baddr(int p, int k);
        int t [8];
        if (p == 0)      t = '{'h90, 'h94, 'h98, 'h9C, 'hA8, 'hA0, 'h00, 'h10};
        else if (p == 1) t = '{'hAC, 'hB0, 'hB4, 'hB8, 'hC4, 'hBC, 'h04, 'h14};
        else             t = '{'h4C, 'h50, 'h54, 'h58, 'h64, -1, 'h30, 'h34};
        return t[k];
    endfunction

    // reference model state
    bit [7:0] m_mode[3], m_pol[3], m_en[3], m_fen[3], m_data[3], m_dir[3];
    bit [7:0] m_s1[3], m_s2[3], m_filt[3], m_prev[3], m_latch[3];
    int       m_run[3][8];
    int       m_tick;

    function automatic bit [7:0] m_q(int p);
        return (m_fen[p] & m_filt[p]) | (~m_fen[p] & m_s2[p]);
    endfunction

    function automatic bit [7:0] m_stat(int p);
        bit [7:0] q;
        q = m_q(p);
        return m_en[p] & ((m_mode[p] & m_latch[p]) | (~m_mode[p] & ~(q ^ m_pol[p])));
    endfunction

    function automatic bit [7:0] m_read(bit [7:0] a);
        for (int p = 0; p < 3; p++) begin
            if (a == baddr(p, 0)) return m_mode[p];
            if (a == baddr(p, 1)) return m_pol[p];
            if (a == baddr(p, 3)) return m_en[p];
            if (a == baddr(p, 4)) return m_fen[p];
            if (p != 2 && a == baddr(p, 5)) return m_stat(p);
            if (a == baddr(p, 6)) return m_data[p];
            if (a == baddr(p, 7)) return m_dir[p];
        end
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        bit       tk;
        bit [7:0] q, rise, fall, clr;
        bit [7:0] setv[3];
        bit [7:0] pin[3];
        if (rst) begin
            for (int p = 0; p < 3; p++) begin
                m_mode[p] = 0; m_pol[p] = 0; m_en[p] = 0; m_fen[p] = 0;
                m_data[p] = 0; m_dir[p] = 0; m_s1[p] = 0; m_s2[p] = 0;
                m_filt[p] = 0; m_prev[p] = 0; m_latch[p] = 0;
                for (int i = 0; i < 8; i++) m_run[p][i] = 0;
            end
            m_tick = 0;
        end else begin
            pin[0] = pin_a; pin[1] = pin_b; pin[2] = pin_f;
            tk = (m_tick == TDIV - 1);
            m_tick = tk ? 0 : m_tick + 1;
            for (int p = 0; p < 3; p++) begin
                q = m_q(p);
                rise = q & ~m_prev[p];
                fall = ~q & m_prev[p];
                setv[p] = m_en[p] & m_mode[p] & ((m_pol[p] & rise) | (~m_pol[p] & fall));
                m_prev[p] = q;
            end
            for (int p = 0; p < 3; p++) begin
                if (tk) begin
                    for (int i = 0; i < 8; i++) begin
                        if (m_s2[p][i] == m_filt[p][i]) m_run[p][i] = 0;
                        else if (m_run[p][i] == FLEN - 1) begin
                            m_filt[p][i] = m_s2[p][i];
                            m_run[p][i] = 0;
                        end else m_run[p][i]++;
                    end
                end
                m_s2[p] = m_s1[p];
                m_s1[p] = pin[p];
                clr = (bus_we && bus_addr == baddr(p, 2)) ? bus_wdata : 8'h00;
                m_latch[p] = (m_latch[p] & ~clr) | setv[p];
                if (bus_we) begin
                    if (bus_addr == baddr(p, 0)) m_mode[p] = bus_wdata;
                    if (bus_addr == baddr(p, 1)) m_pol[p]  = bus_wdata;
                    if (bus_addr == baddr(p, 3)) m_en[p]   = bus_wdata;
                    if (bus_addr == baddr(p, 4)) m_fen[p]  = bus_wdata;
                    if (bus_addr == baddr(p, 6)) m_data[p] = bus_wdata;
                    if (bus_addr == baddr(p, 7)) m_dir[p]  = bus_wdata;
                end
            end
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s at %0t: actual %02h expected %02h", tag, $time, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R7 outputs, R9/R10 read path)
    task automatic cyc();
        @(negedge clk);
        chk("R7 irq_f", irq_f, m_stat(2));
        chk("R7 irq_ab", {7'b0, irq_ab}, {7'b0, (|m_stat(0)) | (|m_stat(1))});
        chk("R9 rdata", bus_rdata, m_read(bus_addr));
    endtask

    task automatic step(int n);
        for (int j = 0; j < n; j++) cyc();
    endtask

    task automatic wr(int a, logic [7:0] d);
        bus_addr = 8'(a); bus_wdata = d; bus_we = 1'b1;
        cyc();
        bus_we = 1'b0;
    endtask

    task automatic rd(string tag, int a, logic [7:0] exp);
        bus_addr = 8'(a);
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc();

        // R11 reset state
        rd("R11 mode A", 'h90, 8'h00);
        rd("R11 en F", 'h58, 8'h00);
        rd("R11 data B", 'h04, 8'h00);
        chk("R11 irq_f", irq_f, 8'h00);
        chk("R11 irq_ab", {7'b0, irq_ab}, 8'h00);

        // R10 data/direction storage and unmapped reads
        wr('h00, 8'h5A); rd("R10 data A", 'h00, 8'h5A);
        wr('h34, 8'hC3); rd("R10 dir F", 'h34, 8'hC3);
        wr('h04, 8'h96); rd("R10 data B", 'h04, 8'h96);
        rd("R10 unmapped", 'h08, 8'h00);

        // R9 config readback on port B, clear register reads zero
        wr('hAC, 8'h11); wr('hB0, 8'h22); wr('hC4, 8'h44);
        rd("R9 mode B", 'hAC, 8'h11);
        rd("R9 pol B", 'hB0, 8'h22);
        rd("R9 filt B", 'hC4, 8'h44);
        wr('hB4, 8'hFF); rd("R9 clr B reads 0", 'hB4, 8'h00);
        wr('hAC, 8'h00); wr('hB0, 8'h00); wr('hC4, 8'h00);

        // R1 level mode on A line 0
        wr('h9C, 8'h01); wr('h94, 8'h01);
        pin_a[0] = 1'b1; step(4);
        rd("R1 level high pending", 'hA0, 8'h01);
        chk("R7 ab merge", {7'b0, irq_ab}, 8'h01);
        pin_a[0] = 1'b0; step(4);
        rd("R1 level gone", 'hA0, 8'h00);
        wr('h94, 8'h00);
        rd("R1 level low pending", 'hA0, 8'h01);
        wr('h9C, 8'h00);
        rd("R4 disabled not pending", 'hA0, 8'h00);

        // R2 rising edge on F line 3, sticky; R3 clear
        wr('h4C, 8'h08); wr('h50, 8'h08); wr('h58, 8'h08);
        pin_f[3] = 1'b1; step(4);
        chk("R2 rise latched", irq_f, 8'h08);
        pin_f[3] = 1'b0; step(4);
        chk("R2 sticky", irq_f, 8'h08);
        wr('h54, 8'hF7);
        chk("R3 zero bit no effect", irq_f, 8'h08);
        wr('h54, 8'h08);
        chk("R3 clear", irq_f, 8'h00);

        // R2 falling edge on F line 4
        wr('h4C, 8'h18); wr('h58, 8'h18);
        pin_f[4] = 1'b1; step(4);
        chk("R2 rise ignored on falling", irq_f, 8'h00);
        pin_f[4] = 1'b0; step(4);
        chk("R2 fall latched", irq_f, 8'h10);
        wr('h54, 8'h10);

        // R4 disabled line 5 sees edges, then reconfigured
        wr('h4C, 8'h38); wr('h50, 8'h28);
        pin_f[5] = 1'b1; step(4); pin_f[5] = 1'b0; step(4); pin_f[5] = 1'b1; step(4);
        wr('h58, 8'h38); step(4);
        chk("R4 no edge while disabled", irq_f, 8'h00);
        wr('h58, 8'h18); wr('h50, 8'h08); wr('h58, 8'h38); step(4);
        chk("R4 reconfig no spurious", irq_f, 8'h00);
        pin_f[5] = 1'b0; step(4);
        chk("R4 enabled line latches", irq_f, 8'h20);
        wr('h54, 8'h20);

        // R5 synchronizer latency, level high on F line 0
        wr('h4C, 8'h38); wr('h50, 8'h09); wr('h58, 8'h39);
        pin_f[0] = 1'b1;
        cyc(); chk("R5 one edge not yet", irq_f & 8'h01, 8'h00);
        cyc(); chk("R5 two edges visible", irq_f & 8'h01, 8'h01);
        pin_f[0] = 1'b0; step(4);

        // R3 clear colliding with new edge on F line 3
        pin_f[3] = 1'b1;
        cyc(); cyc();
        bus_addr = 8'h54; bus_wdata = 8'h08; bus_we = 1'b1;
        cyc();
        bus_we = 1'b0;
        chk("R3 edge wins over clear", irq_f & 8'h08, 8'h08);
        wr('h54, 8'h08);
        chk("R3 cleared after", irq_f & 8'h08, 8'h00);
        pin_f[3] = 1'b0; step(4);
        wr('h54, 8'hFF);

        // R6 filter on F line 6, level high
        wr('h64, 8'h40); wr('h50, 8'h49); wr('h58, 8'h79);
        pin_f[6] = 1'b1; step(3); pin_f[6] = 1'b0; step(40);
        chk("R6 glitch rejected", irq_f & 8'h40, 8'h00);
        pin_f[6] = 1'b1; step(8);
        chk("R6 not yet stable", irq_f & 8'h40, 8'h00);
        step(30);
        chk("R6 stable passes", irq_f & 8'h40, 8'h40);
        pin_f[6] = 1'b0; step(40);

        // R8 port B status, R7 merge
        wr('hB8, 8'h80); step(3);
        rd("R8 status B", 'hBC, 8'h80);
        chk("R7 ab from B", {7'b0, irq_ab}, 8'h01);
        pin_b[7] = 1'b1; step(4);
        rd("R8 status B gone", 'hBC, 8'h00);

        // random mix checked against the model every cycle
        for (int n = 0; n < 3000; n++) begin
            int p, k;
            if (bus_we) bus_we = 1'b0;
            else if ($urandom_range(9) == 0) begin
                p = $urandom_range(2);
                k = $urandom_range(7);
                if (k == 5) k = 2;
                bus_addr = 8'(baddr(p, k));
                bus_wdata = 8'($urandom);
                bus_we = 1'b1;
            end else begin
                p = $urandom_range(2);
                k = $urandom_range(7);
                bus_addr = (p == 2 && k == 5) ? 8'h08 : 8'(baddr(p, k));
            end
            if ($urandom_range(5) == 0) begin
                p = $urandom_range(2);
                k = $urandom_range(7);
                if (p == 0) pin_a[k] = ~pin_a[k];
                else if (p == 1) pin_b[k] = ~pin_b[k];
                else pin_f[k] = ~pin_f[k];
            end
            cyc();
        end
        bus_we = 1'b0;
        step(2);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule